// File: doc/BRIEF.md
# Gated Multi-Mode Timer/Counter

This block is a general-purpose timer/counter whose count is held in two byte registers, a low byte and a high byte. It can advance on an internal machine-cycle tick, which fires once every twelve clock cycles, or on falling edges of an external event input. A run control, a gate enable and an external gate pin together decide when counting is allowed. A two-bit mode field selects one of four arrangements of the two bytes: a 13-bit count whose low five bits act as a prescaler, a full 16-bit count, an 8-bit count that reloads from the high byte, or a split arrangement with two independent 8-bit timers.

Each count byte can be loaded directly through a small register write port, and both bytes are always visible on output ports. Every roll-over raises a sticky overflow flag and a one-clock overflow pulse. Another block can use that pulse as a rate tick, for example a baud tick. The flag is cleared by an acknowledge input or by a direct software write. There are two flag channels. Channel 0 belongs to the main counter. Channel 1 belongs to the high-byte timer, which exists only in split mode and has its own run control.

Top module: `tmr_gated_timer`

## Requirements
- R1: In timer function (`sel_event`=0) an enabled counter advances by exactly one on every machine-cycle tick. A tick fires once every 12 clocks, so any 48 consecutive clocks contain exactly 4 ticks.
- R2: With `mode`=00 the count is 13 bits wide. Bits [4:0] of the low byte form a prescaler. When they wrap from 31 to 0 the high byte increments. Bits [7:5] of the low byte are held. The count overflows when the high byte wraps from FF to 00.
- R3: With `mode`=01 the high and low bytes form one 16-bit count, and it overflows on the step from FFFF to 0000.
- R4: With `mode`=10 only the low byte counts. On the step past FF it loads the high-byte value and overflows. The high byte is left unchanged.
- R5: With `mode`=11 the low byte is an 8-bit counter under the main controls and uses flag channel 0. The high byte counts machine cycles whenever `run_hi` is 1, with no gating, and overflows into channel 1. Channel 1 never overflows in any other mode.
- R6: When `gate_en`=1, counting needs both `run_en`=1 and `gate_pin`=1. When `gate_en`=0, `run_en` alone enables counting. While counting is disabled the count holds.
- R7: In counter function (`sel_event`=1) `event_pin` is sampled on each machine-cycle tick. A 1 followed by a 0 in two consecutive samples counts one event, and the count advances one clock after the sample that sees the 0.
- R8: An overflow sets the channel's flag and drives its pulse high for one clock, on the same clock edge at which the count rolls over.
- R9: `ack[k]`=1 clears flag k. A hardware overflow in the same cycle wins over the acknowledge.
- R10: `flag_wr_en[k]`=1 loads `flag_wr_val[k]` into flag k, with priority over both overflow and acknowledge.
- R11: A write with `wr_en`=1 loads `wr_data` into the low byte (`wr_sel`=0) or the high byte (`wr_sel`=1). A write takes priority over an increment in the same cycle, and that increment is dropped with no overflow. In split mode a write drops only the increment of the byte it targets.
- R12: After reset both count bytes, both flags and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run control of the main counter |
| gate_en | input | 1 | When 1, counting also needs gate_pin high |
| gate_pin | input | 1 | External gate level |
| sel_event | input | 1 | 0 counts machine cycles, 1 counts falling edges of event_pin |
| event_pin | input | 1 | External event input |
| mode | input | 2 | 00 13-bit, 01 16-bit, 10 8-bit reload, 11 split |
| run_hi | input | 1 | Run control of the high-byte timer in split mode |
| wr_en | input | 1 | Count byte write strobe |
| wr_sel | input | 1 | Write target: 0 low byte, 1 high byte |
| wr_data | input | 8 | Write data |
| flag_wr_en | input | 2 | Per-channel flag write strobe |
| flag_wr_val | input | 2 | Per-channel flag write value |
| ack | input | 2 | Per-channel flag acknowledge |
| count_lo | output | 8 | Low count byte |
| count_hi | output | 8 | High count byte |
| ovf_flag | output | 2 | Sticky overflow flags (0 main, 1 high-byte timer) |
| ovf_pulse | output | 2 | One-clock overflow pulses |

## Verification
Each mode is preloaded just below its roll-over point and then run for a fixed number of ticks. The resulting byte values separate prescaler carry from a plain 16-bit carry and separate reload from wrap, and they show that the upper bits of the low byte are held in 13-bit mode. The gate pin is held low and then high with the gate enabled, and then the gate is disabled with the pin low, to tell gating apart from run control. A slow square wave on the event pin checks that the count equals the number of falling edges, independent of the tick rate. Back-to-back writes across a tick, and split mode with the second run control toggled, check write priority and that the two byte timers are independent.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmr_mode_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int CYC_DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (cnt_q == LAST);
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/tmr_evt_sampler.sv
module tmr_evt_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  output logic evt
);
  logic smp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= 1'b0;
      evt   <= 1'b0;
    end else if (tick) begin
      smp_q <= pin;
      evt   <= smp_q & ~pin;
    end else begin
      evt   <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_mode_e         mode,
  input  logic              inc_main,
  input  logic              inc_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic [1:0]        ovf_evt
);
  localparam int WIDE = 2 * BYTE_W + 1;

  logic [BYTE_W-1:0] lo_n, hi_n;
  logic [BYTE_W:0]   lo_sum, hi_sum;
  logic [WIDE-1:0]   wide_sum;
  logic              main_wr, split;

  always_comb begin
    lo_sum   = {1'b0, lo_q} + (BYTE_W + 1)'(1);
    hi_sum   = {1'b0, hi_q} + (BYTE_W + 1)'(1);
    wide_sum = {1'b0, hi_q, lo_q} + WIDE'(1);
    split    = (mode == MODE_SPLIT);
    main_wr  = split ? wr_lo : (wr_lo | wr_hi);
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_evt  = '0;

    if (inc_main && !main_wr) begin
      unique case (mode)
        MODE_13: begin
          if (lo_q[PRESC_W-1:0] == '1) begin
            lo_n[PRESC_W-1:0]   = '0;
            {ovf_evt[0], hi_n}  = hi_sum;
          end else begin
            lo_n[PRESC_W-1:0] = lo_q[PRESC_W-1:0] + PRESC_W'(1);
          end
        end
        MODE_16: {ovf_evt[0], hi_n, lo_n} = wide_sum;
        MODE_RELOAD: begin
          if (lo_sum[BYTE_W]) begin
            lo_n       = hi_q;
            ovf_evt[0] = 1'b1;
          end else begin
            lo_n = lo_sum[BYTE_W-1:0];
          end
        end
        MODE_SPLIT: {ovf_evt[0], lo_n} = lo_sum;
      endcase
    end

    if (split && inc_hi && !wr_hi) {ovf_evt[1], hi_n} = hi_sum;

    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit (
  input  logic clk,
  input  logic rst,
  input  logic ovf_evt,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic ack,
  output logic flag,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= ovf_evt;
      if (sw_wr)        flag <= sw_val;
      else if (ovf_evt) flag <= 1'b1;
      else if (ack)     flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_gated_timer.sv
module tmr_gated_timer
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5,
  parameter int CYC_DIV = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              gate_en,
  input  logic              gate_pin,
  input  logic              sel_event,
  input  logic              event_pin,
  input  logic [1:0]        mode,
  input  logic              run_hi,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        flag_wr_en,
  input  logic [1:0]        flag_wr_val,
  input  logic [1:0]        ack,
  output logic [BYTE_W-1:0] count_lo,
  output logic [BYTE_W-1:0] count_hi,
  output logic [1:0]        ovf_flag,
  output logic [1:0]        ovf_pulse
);
  logic       mc_tick, evt_tick, cnt_src, cnt_allow;
  logic [1:0] ovf_evt;
  tmr_mode_e  mode_e;

  assign mode_e    = tmr_mode_e'(mode);
  assign cnt_src   = sel_event ? evt_tick : mc_tick;
  assign cnt_allow = run_en & (~gate_en | gate_pin);

  tmr_tick_gen #(.CYC_DIV(CYC_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(mc_tick)
  );

  tmr_evt_sampler u_evt (
    .clk(clk), .rst(rst), .tick(mc_tick), .pin(event_pin), .evt(evt_tick)
  );

  tmr_count_core #(.BYTE_W(BYTE_W), .PRESC_W(PRESC_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_e),
    .inc_main (cnt_allow & cnt_src),
    .inc_hi   (run_hi & mc_tick),
    .wr_lo    (wr_en & ~wr_sel),
    .wr_hi    (wr_en & wr_sel),
    .wr_data  (wr_data),
    .lo_q     (count_lo),
    .hi_q     (count_hi),
    .ovf_evt  (ovf_evt)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_flag
    tmr_flag_unit u_flag (
      .clk     (clk),
      .rst     (rst),
      .ovf_evt (ovf_evt[k]),
      .sw_wr   (flag_wr_en[k]),
      .sw_val  (flag_wr_val[k]),
      .ack     (ack[k]),
      .flag    (ovf_flag[k]),
      .pulse   (ovf_pulse[k])
    );
  end
endmodule

// File: rtl/tmr_gated_timer_chk.sv
module tmr_gated_timer_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              gate_en,
  input logic              gate_pin,
  input logic [1:0]        mode,
  input logic              run_hi,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic [1:0]        flag_wr_en,
  input logic [1:0]        ack,
  input logic [BYTE_W-1:0] count_lo,
  input logic [BYTE_W-1:0] count_hi,
  input logic [1:0]        ovf_flag,
  input logic [1:0]        ovf_pulse
);
  // R4: reload overflow leaves the old high byte in the low byte
  p_reload_value_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse[0] && $past(mode) == 2'b10) |-> count_lo == $past(count_hi));

  // R5: second channel only overflows in split mode
  p_hi_ovf_split_only_r5: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b11) |=> !ovf_pulse[1]);

  // R5: high-byte timer holds while its run control is low
  p_hi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && !run_hi && !(wr_en && wr_sel)) |=> $stable(count_hi));

  // R6: run off freezes the count outside split mode
  p_run_off_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_en && mode != 2'b11) |=> $stable({count_hi, count_lo}));

  // R6: closed gate freezes the count outside split mode
  p_gate_closed_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (gate_en && !gate_pin && !wr_en && mode != 2'b11) |=> $stable({count_hi, count_lo}));

  // R8: a pulse is accompanied by a set flag unless software overrode it
  p_pulse_sets_flag0_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse[0] && !$past(flag_wr_en[0])) |-> ovf_flag[0]);
  p_pulse_sets_flag1_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse[1] && !$past(flag_wr_en[1])) |-> ovf_flag[1]);

  // R9: acknowledge clears unless an overflow lands in the same cycle
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (ack[0] && !flag_wr_en[0]) |=> (!ovf_flag[0] || ovf_pulse[0]));

  // R11: byte writes always land
  p_wr_lo_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |=> count_lo == $past(wr_data));
  p_wr_hi_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> count_hi == $past(wr_data));
endmodule

bind tmr_gated_timer tmr_gated_timer_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/test_tmr_gated_timer.sv
`timescale 1ns/1ps
module test_tmr_gated_timer;
  localparam int DIV = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 0, gate_en = 0, gate_pin = 0, sel_event = 0, event_pin = 1;
  logic [1:0] mode = 2'b01;
  logic       run_hi = 0, wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] flag_wr_en = 0, flag_wr_val = 0, ack = 0;
  logic [7:0] count_lo, count_hi;
  logic [1:0] ovf_flag, ovf_pulse;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  int m_pre = 0, m_lo = 0, m_hi = 0;
  bit m_tick = 0, m_smp = 0, m_evt = 0;
  bit m_flg[2];
  bit m_pul[2];

  always #2 clk = ~clk;

  tmr_gated_timer i_tmr_gated_timer (
    .clk(clk), .rst(rst), .run_en(run_en), .gate_en(gate_en), .gate_pin(gate_pin),
    .sel_event(sel_event), .event_pin(event_pin), .mode(mode), .run_hi(run_hi),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .flag_wr_en(flag_wr_en),
    .flag_wr_val(flag_wr_val), .ack(ack), .count_lo(count_lo), .count_hi(count_hi),
    .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(string tag, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string mode_tag();
    if (sel_event) return "R7";
    case (mode)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic model_update();
    int nlo, nhi, v;
    bit ntick, nsmp, nevt, src, en, inc, split, wlo, whi, mwr;
    bit o[2];
    if (rst) begin
      m_pre = 0; m_lo = 0; m_hi = 0; m_tick = 0; m_smp = 0; m_evt = 0;
      m_flg[0] = 0; m_flg[1] = 0; m_pul[0] = 0; m_pul[1] = 0;
      return;
    end
    ntick = (m_pre == DIV - 1);
    if (m_tick) begin nsmp = event_pin; nevt = m_smp && !event_pin; end
    else begin nsmp = m_smp; nevt = 0; end
    src   = sel_event ? m_evt : m_tick;
    en    = run_en && (!gate_en || gate_pin);
    inc   = en && src;
    split = (mode == 2'b11);
    wlo   = wr_en && !wr_sel;
    whi   = wr_en && wr_sel;
    mwr   = split ? wlo : wr_en;
    o[0] = 0; o[1] = 0; nlo = m_lo; nhi = m_hi;
    if (inc && !mwr) begin
      case (mode)
        2'b00: begin
          if ((m_lo % 32) == 31) begin
            nlo = m_lo - 31;
            if (m_hi == 255) begin nhi = 0; o[0] = 1; end else nhi = m_hi + 1;
          end else nlo = m_lo + 1;
        end
        2'b01: begin
          v = m_hi * 256 + m_lo + 1;
          if (v == 65536) begin v = 0; o[0] = 1; end
          nlo = v % 256; nhi = v / 256;
        end
        2'b10: begin
          if (m_lo == 255) begin nlo = m_hi; o[0] = 1; end else nlo = m_lo + 1;
        end
        default: begin
          o[0] = (m_lo == 255); nlo = (m_lo + 1) % 256;
        end
      endcase
    end
    if (split && run_hi && m_tick && !whi) begin
      o[1] = (m_hi == 255); nhi = (m_hi + 1) % 256;
    end
    if (wlo) nlo = wr_data;
    if (whi) nhi = wr_data;
    for (int k = 0; k < 2; k++) begin
      if (flag_wr_en[k]) m_flg[k] = flag_wr_val[k];
      else if (o[k])     m_flg[k] = 1;
      else if (ack[k])   m_flg[k] = 0;
      m_pul[k] = o[k];
    end
    m_pre = (m_pre + 1) % DIV; m_tick = ntick; m_smp = nsmp; m_evt = nevt;
    m_lo = nlo; m_hi = nhi;
  endtask

  task automatic compare();
    string t;
    t = rst ? "R12" : mode_tag();
    chk(t, count_lo, m_lo, "count_lo");
    chk(t, count_hi, m_hi, "count_hi");
    chk("R8", ovf_flag, {m_flg[1], m_flg[0]}, "ovf_flag");
    chk("R8", ovf_pulse, {m_pul[1], m_pul[0]}, "ovf_pulse");
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic run_for(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_byte(bit sel, logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic ack_all();
    ack = 2'b11; step(); ack = 2'b00;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    run_for(3);
    rst = 0;
    step();
    // R12: reset state
    chk("R12", count_lo, 0, "reset count_lo");
    chk("R12", count_hi, 0, "reset count_hi");
    chk("R12", ovf_flag, 0, "reset flags");

    // R3/R1/R8: 16-bit roll FFFD + 4 ticks
    mode = 2'b01; wr_byte(0, 8'hFD); wr_byte(1, 8'hFF);
    run_en = 1; run_for(4 * DIV); run_en = 0;
    chk("R3", {count_hi, count_lo}, 16'h0001, "16-bit roll");
    chk("R1", count_lo, 8'h01, "four ticks in 48 clocks");
    chk("R8", ovf_flag[0], 1, "flag after 16-bit overflow");

    // R9: acknowledge clears
    ack = 2'b01; step(); ack = 0;
    chk("R9", ovf_flag[0], 0, "ack clears flag");

    // R10: software flag writes
    flag_wr_en = 2'b01; flag_wr_val = 2'b01; step();
    chk("R10", ovf_flag[0], 1, "software set");
    flag_wr_val = 2'b00; step(); flag_wr_en = 0;
    chk("R10", ovf_flag[0], 0, "software clear");

    // R4: reload mode FE, reload value F0
    mode = 2'b10; wr_byte(1, 8'hF0); wr_byte(0, 8'hFE);
    run_en = 1; run_for(4 * DIV); run_en = 0;
    chk("R4", count_lo, 8'hF2, "reload then two counts");
    chk("R4", count_hi, 8'hF0, "reload source unchanged");
    chk("R4", ovf_flag[0], 1, "reload overflow flag");
    ack_all();

    // R2: 13-bit mode, upper low bits held
    mode = 2'b00; wr_byte(1, 8'hFF); wr_byte(0, 8'hFE);
    run_en = 1; run_for(4 * DIV); run_en = 0;
    chk("R2", count_lo, 8'hE2, "prescaler wrap keeps bits 7:5");
    chk("R2", count_hi, 8'h00, "high byte wrap");
    chk("R2", ovf_flag[0], 1, "13-bit overflow flag");
    ack_all();

    // R6: gating
    mode = 2'b01; wr_byte(0, 8'h00); wr_byte(1, 8'h00);
    gate_en = 1; gate_pin = 0; run_en = 1; run_for(4 * DIV);
    chk("R6", count_lo, 0, "gate pin low blocks");
    gate_pin = 1; run_for(4 * DIV);
    chk("R6", count_lo, 4, "gate pin high counts");
    gate_en = 0; gate_pin = 0; run_for(2 * DIV);
    chk("R6", count_lo, 6, "gate disabled ignores pin");
    run_en = 0; run_for(2 * DIV);
    chk("R6", count_lo, 6, "run off holds");

    // R7: event counting, five falling edges
    wr_byte(0, 8'h00); sel_event = 1; run_en = 1; event_pin = 1;
    run_for(30);
    for (int i = 0; i < 5; i++) begin
      event_pin = 0; run_for(30);
      event_pin = 1; run_for(30);
    end
    run_for(36);
    chk("R7", count_lo, 5, "falling edge count");
    run_en = 0; sel_event = 0;

    // R5: split mode, two independent 8-bit timers
    mode = 2'b11; wr_byte(0, 8'hFE); wr_byte(1, 8'hFD);
    run_en = 1; run_hi = 1; run_for(4 * DIV);
    chk("R5", count_lo, 8'h02, "split low byte");
    chk("R5", count_hi, 8'h01, "split high byte");
    chk("R5", ovf_flag, 2'b11, "both channel flags");
    run_hi = 0; run_for(4 * DIV);
    chk("R5", count_hi, 8'h01, "high timer stopped");
    chk("R5", count_lo, 8'h06, "low timer keeps running");
    run_en = 0; ack_all();

    // R11: writes win over increments
    mode = 2'b01; run_en = 1;
    for (int i = 0; i < 13; i++) wr_byte(0, 8'h40 + 8'(i));
    chk("R11", count_lo, 8'h4C, "last write kept");
    chk("R11", count_hi, 8'h01, "dropped increment leaves high byte");
    run_en = 0; run_for(DIV);

    finish_run();
  end
endmodule